// File: doc/BRIEF.md
# Floppy Disk Controller Register Model

This block presents a byte-wide register window that drives a sector-addressed disk image held in on-chip RAM. A host writes a command byte. Each command passes through a fixed preparation interval and then an execution interval before the block goes idle again. Head positioning commands only update the track register and the track-zero flag. Sector commands compute a linear byte pointer into the image. The host then moves one byte per data-register access, and each access extends the execution interval.

The side used for addressing comes from a 1-bit input that another peripheral drives. The geometry (sides, sectors per track, bytes per sector) and the image depth are parameters, so a reduced image can stand in for a full disk. The pointer wraps modulo the image depth.

Top module: `disk_ctrl`

## Requirements
- R1: After reset, the status register reads 0x80, the track and sector registers read 0, and err_o is 0.
- R2: A command write at a clock edge starts a preparation phase of PREP_CYC edges, with busy clear. An execution phase of EXEC_CYC edges follows, with busy set. The block is then idle.
- R3: Status layout at offset 0: bit 7 always reads 1, bit 0 is busy, bit 2 is the track-zero flag, and bit 1 (data request) is set only during execution of read-sector (0x80, 0x90) or write-sector (0xA0, 0xA2) commands. All other bits read 0.
- R4: Restore (0x00) clears the track register and sets track-zero.
- R5: Seek (0x10) and seek-with-verify (0x14) copy the data register into the track register. They set track-zero exactly when the copied value is 0.
- R6: A sector command sets the pointer to ((track*SIDES + side)*SECT_PER_TRK + sector - 1)*SECT_BYTES and clears track-zero. Successive transfers are contiguous across sector boundaries.
- R7: During execution of a read-sector command, a data read at offset 3 returns the image byte at the pointer, advances the pointer, and reloads the execution counter to EXEC_CYC.
- R8: During execution of a write-sector command, a data write stores the byte at the pointer, advances the pointer, and reloads the execution counter. At any other time, a data write only loads the data register.
- R9: Force interrupt (0xD0) makes the block idle at the next edge, with no preparation, and clears track-zero.
- R10: side_i selects which side enters the pointer calculation at the moment a sector command is written.
- R11: A data read outside read-sector execution, or a write-track command (0xF0), sets err_o. err_o stays set until reset, and the image is not changed.
- R12: The track (offset 1) and sector (offset 2) registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Access strobe, one access per cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| off_i | input | 2 | Register offset: 0 command/status, 1 track, 2 sector, 3 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for off_i, combinational |
| side_i | input | 1 | Selected side from the external configuration peripheral |
| err_o | output | 1 | Sticky error flag |

## Verification
A wrong phase counter shows up in the busy bit. That bit must rise exactly PREP_CYC edges after a command and fall EXEC_CYC edges after the last transfer, so an off-by-one is caught at the first edge it affects. A wrong pointer or a missed advance returns the wrong byte on the next data read of a crossed-boundary sequence. A pointer computed with the wrong side only shows when the other side's sector is read back. A lost error flag is seen as soon as err_o is sampled after the offending access.

// File: rtl/disk_ctrl_pkg.sv
package disk_ctrl_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_PREP, PH_EXEC} phase_e;

  localparam logic [1:0] OFF_CMD = 2'd0;
  localparam logic [1:0] OFF_TRK = 2'd1;
  localparam logic [1:0] OFF_SEC = 2'd2;
  localparam logic [1:0] OFF_DAT = 2'd3;

  localparam logic [7:0] CMD_RESTORE  = 8'h00;
  localparam logic [7:0] CMD_SEEK     = 8'h10;
  localparam logic [7:0] CMD_SEEK_VFY = 8'h14;
  localparam logic [7:0] CMD_RD       = 8'h80;
  localparam logic [7:0] CMD_RD_MULTI = 8'h90;
  localparam logic [7:0] CMD_WR_PROT  = 8'hA0;
  localparam logic [7:0] CMD_WR       = 8'hA2;
  localparam logic [7:0] CMD_ABORT    = 8'hD0;
  localparam logic [7:0] CMD_FMT      = 8'hF0;

  function automatic logic is_rd_cmd(logic [7:0] c);
    return (c == CMD_RD) || (c == CMD_RD_MULTI);
  endfunction

  function automatic logic is_wr_cmd(logic [7:0] c);
    return (c == CMD_WR_PROT) || (c == CMD_WR);
  endfunction
endpackage

// File: rtl/disk_seq.sv
module disk_seq
  import disk_ctrl_pkg::*;
#(
  parameter int PREP_CYC = 10,
  parameter int EXEC_CYC = 10
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   abort_i,
  input  logic   reload_i,
  output phase_e phase_o
);
  localparam int MAX_CYC = (PREP_CYC > EXEC_CYC) ? PREP_CYC : EXEC_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (abort_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_PREP;
      cnt_q   <= CW'(PREP_CYC);
    end else begin
      unique case (phase_q)
        PH_PREP: begin
          if (cnt_q == CW'(1)) begin
            phase_q <= PH_EXEC;
            cnt_q   <= CW'(EXEC_CYC);
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        PH_EXEC: begin
          if (reload_i) begin
            cnt_q <= CW'(EXEC_CYC);
          end else if (cnt_q == CW'(1)) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign phase_o = phase_q;

  a_r2_exec_from_prep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && $past(phase_q) != PH_EXEC) |-> $past(phase_q) == PH_PREP);
  a_r2_active_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |-> (cnt_q != '0));
  a_r9_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/disk_lba.sv
module disk_lba #(
  parameter int SIDES        = 2,
  parameter int SECT_PER_TRK = 9,
  parameter int SECT_BYTES   = 512,
  parameter int AW           = 20
) (
  input  logic [7:0]    trk_i,
  input  logic          side_i,
  input  logic [7:0]    sec_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] sec_idx;

  always_comb begin
    sec_idx = (AW'(trk_i) * AW'(SIDES) + AW'(side_i)) * AW'(SECT_PER_TRK)
              + AW'(sec_i) - AW'(1);
    addr_o  = sec_idx * AW'(SECT_BYTES);
  end
endmodule

// File: rtl/disk_img.sv
module disk_img #(
  parameter int DEPTH = 4096,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/disk_ctrl.sv
module disk_ctrl
  import disk_ctrl_pkg::*;
#(
  parameter int SIDES        = 2,
  parameter int SECT_PER_TRK = 9,
  parameter int SECT_BYTES   = 512,
  parameter int IMG_BYTES    = 4096,
  parameter int ADDR_W       = 20,
  parameter int PREP_CYC     = 10,
  parameter int EXEC_CYC     = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       we_i,
  input  logic [1:0] off_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       side_i,
  output logic       err_o
);
  localparam int IMG_AW = $clog2(IMG_BYTES);

  logic [7:0]        trk_q, sec_q, dat_q, cmd_q;
  logic              trk0_q, err_q;
  logic [ADDR_W-1:0] ptr_q, lba;
  logic [7:0]        img_rd;
  phase_e            phase;

  logic wr_acc, rd_acc, cmd_wr, abort, start, exec, rd_mode, wr_mode;
  logic dat_rd, dat_wr, xfer_rd, xfer_wr;

  assign wr_acc  = cs_i & we_i;
  assign rd_acc  = cs_i & ~we_i;
  assign cmd_wr  = wr_acc && (off_i == OFF_CMD);
  assign abort   = cmd_wr && (wdata_i == CMD_ABORT);
  assign start   = cmd_wr && !abort;
  assign exec    = (phase == PH_EXEC);
  assign rd_mode = exec && is_rd_cmd(cmd_q);
  assign wr_mode = exec && is_wr_cmd(cmd_q);
  assign dat_rd  = rd_acc && (off_i == OFF_DAT);
  assign dat_wr  = wr_acc && (off_i == OFF_DAT);
  assign xfer_rd = dat_rd && rd_mode;
  assign xfer_wr = dat_wr && wr_mode;

  disk_seq #(.PREP_CYC(PREP_CYC), .EXEC_CYC(EXEC_CYC)) seq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .abort_i  (abort),
    .reload_i (xfer_rd | xfer_wr),
    .phase_o  (phase)
  );

  disk_lba #(
    .SIDES(SIDES), .SECT_PER_TRK(SECT_PER_TRK), .SECT_BYTES(SECT_BYTES), .AW(ADDR_W)
  ) lba_i (
    .trk_i  (trk_q),
    .side_i (side_i),
    .sec_i  (sec_q),
    .addr_o (lba)
  );

  disk_img #(.DEPTH(IMG_BYTES)) img_i (
    .clk_i   (clk_i),
    .we_i    (xfer_wr),
    .addr_i  (ptr_q[IMG_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (img_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_q  <= '0;
      sec_q  <= '0;
      dat_q  <= '0;
      cmd_q  <= CMD_ABORT;
      trk0_q <= 1'b0;
      err_q  <= 1'b0;
      ptr_q  <= '0;
    end else if (abort) begin
      cmd_q  <= CMD_ABORT;
      trk0_q <= 1'b0;
    end else if (start) begin
      cmd_q <= wdata_i;
      if (wdata_i == CMD_RESTORE) begin
        trk_q  <= '0;
        trk0_q <= 1'b1;
      end else if (wdata_i == CMD_SEEK || wdata_i == CMD_SEEK_VFY) begin
        trk_q  <= dat_q;
        trk0_q <= (dat_q == 8'd0);
      end else if (is_rd_cmd(wdata_i) || is_wr_cmd(wdata_i)) begin
        ptr_q  <= lba;
        trk0_q <= 1'b0;
      end else if (wdata_i == CMD_FMT) begin
        trk0_q <= 1'b0;
        err_q  <= 1'b1;
      end
    end else if (wr_acc && off_i == OFF_TRK) begin
      trk_q <= wdata_i;
    end else if (wr_acc && off_i == OFF_SEC) begin
      sec_q <= wdata_i;
    end else if (xfer_wr || xfer_rd) begin
      ptr_q <= ptr_q + ADDR_W'(1);
    end else if (dat_wr) begin
      dat_q <= wdata_i;
    end else if (dat_rd) begin
      err_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_CMD: rdata_o = {1'b1, 4'b0000, trk0_q, rd_mode | wr_mode, exec};
      OFF_TRK: rdata_o = trk_q;
      OFF_SEC: rdata_o = sec_q;
      default: rdata_o = rd_mode ? img_rd : dat_q;
    endcase
  end

  assign err_o = err_q;

  a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r7_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_rd || xfer_wr) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));
  a_r4_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && wdata_i == CMD_RESTORE) |=> (trk_q == 8'd0 && trk0_q));
  a_r9_abort_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!trk0_q && phase == PH_IDLE));
  a_r8_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_wr |=> $stable(dat_q));
endmodule

// File: tb/disk_ctrl_tb_top.sv
module disk_ctrl_tb_top;
  localparam int SPT = 3;
  localparam int SB  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0, side = 1'b0;
  logic [1:0] off = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] model [256];

  always #2 clk = ~clk;

  disk_ctrl #(
    .SIDES(2), .SECT_PER_TRK(SPT), .SECT_BYTES(SB), .IMG_BYTES(256),
    .ADDR_W(16), .PREP_CYC(10), .EXEC_CYC(10)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .off_i(off),
    .wdata_i(wdata), .rdata_o(rdata), .side_i(side), .err_o(err)
  );

  function automatic int lin(int t, int s, int k);
    return ((t * 2 + s) * SPT + k - 1) * SB;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=0x%02h exp=0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_wr(logic [1:0] o, logic [7:0] v);
    cs = 1'b1; we = 1'b1; off = o; wdata = v;
    @(posedge clk); @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] o, output logic [7:0] v);
    cs = 1'b1; we = 1'b0; off = o;
    #1 v = rdata;
    @(posedge clk); @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic peek(logic [1:0] o, output logic [7:0] v);
    off = o;
    #1 v = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(2'd0, v); check("R1 status", v, 8'h80);
    peek(2'd1, v); check("R1 track", v, 8'h00);
    peek(2'd2, v); check("R1 sector", v, 8'h00);
    check("R1 err", {7'd0, err}, 8'h00);
  endtask

  task automatic t_restore();
    logic [7:0] v;
    bus_wr(2'd1, 8'd5);  peek(2'd1, v); check("R12 track rb", v, 8'd5);
    bus_wr(2'd2, 8'd7);  peek(2'd2, v); check("R12 sector rb", v, 8'd7);
    bus_wr(2'd0, 8'h00);
    peek(2'd1, v); check("R4 track cleared", v, 8'd0);
    peek(2'd0, v); check("R2 prep start", v, 8'h84);
    tick(9); peek(2'd0, v); check("R2 prep end", v, 8'h84);
    tick(1); peek(2'd0, v); check("R2 exec start", v, 8'h85);
    tick(9); peek(2'd0, v); check("R2 exec end", v, 8'h85);
    tick(1); peek(2'd0, v); check("R2 idle", v, 8'h84);
  endtask

  task automatic t_seek();
    logic [7:0] v;
    bus_wr(2'd3, 8'd3);
    bus_wr(2'd0, 8'h10);
    peek(2'd1, v); check("R5 seek track", v, 8'd3);
    peek(2'd0, v); check("R5 trk0 clear", v, 8'h80);
    tick(10); peek(2'd0, v); check("R3 no drq on seek", v, 8'h81);
    tick(10);
    bus_wr(2'd3, 8'd0);
    bus_wr(2'd0, 8'h14);
    peek(2'd1, v); check("R5 verify seek track", v, 8'd0);
    peek(2'd0, v); check("R5 trk0 set", v, 8'h84);
    tick(20);
  endtask

  task automatic wr_sector(int t, int s, int k, int seed);
    logic [7:0] v;
    bus_wr(2'd1, 8'(t)); bus_wr(2'd2, 8'(k)); side = s[0];
    bus_wr(2'd0, 8'hA2);
    tick(10);
    peek(2'd0, v); check("R3 R6 write exec status", v, 8'h83);
    for (int i = 0; i < SB; i++) begin
      bus_wr(2'd3, 8'(seed + i));
      model[lin(t, s, k) + i] = 8'(seed + i);
    end
    tick(10);
    peek(2'd0, v); check("R8 write done idle", v, 8'h80);
  endtask

  task automatic rd_check(string req, int t, int s, int k, int n);
    logic [7:0] v;
    bus_wr(2'd1, 8'(t)); bus_wr(2'd2, 8'(k)); side = s[0];
    bus_wr(2'd0, 8'h90);
    tick(10);
    for (int i = 0; i < n; i++) begin
      bus_rd(2'd3, v);
      check(req, v, model[lin(t, s, k) + i]);
    end
    tick(9); peek(2'd0, v); check("R7 reload keeps busy", v, 8'h83);
    tick(1); peek(2'd0, v); check("R7 idle after last byte", v, 8'h80);
  endtask

  task automatic t_sectors();
    logic [7:0] v;
    bus_wr(2'd3, 8'd7);
    wr_sector(2, 1, 2, 8'h40);
    wr_sector(2, 1, 1, 8'h20);
    rd_check("R6 R7 contiguous read", 2, 1, 1, 2 * SB);
    wr_sector(2, 0, 2, 8'h90);
    rd_check("R10 side 1 kept", 2, 1, 2, SB);
    rd_check("R10 side 0 data", 2, 0, 2, SB);
    bus_wr(2'd0, 8'h10);
    peek(2'd1, v); check("R8 data reg untouched by transfers", v, 8'd7);
    tick(20);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    bus_wr(2'd0, 8'h80);
    tick(12);
    peek(2'd0, v); check("R9 busy before abort", v, 8'h83);
    bus_wr(2'd0, 8'hD0);
    peek(2'd0, v); check("R9 abort exec", v, 8'h80);
    bus_wr(2'd0, 8'h00);
    tick(3);
    bus_wr(2'd0, 8'hD0);
    peek(2'd0, v); check("R9 abort prep clears trk0", v, 8'h80);
    tick(1); peek(2'd0, v); check("R9 stays idle", v, 8'h80);
  endtask

  task automatic t_err();
    logic [7:0] v;
    check("R11 no err yet", {7'd0, err}, 8'h00);
    bus_wr(2'd0, 8'hF0);
    check("R11 format err", {7'd0, err}, 8'h01);
    tick(25);
    check("R11 sticky", {7'd0, err}, 8'h01);
    do_reset();
    t_reset();
    bus_rd(2'd3, v);
    check("R11 stray data read err", {7'd0, err}, 8'h01);
    rd_check("R11 image unchanged", 2, 1, 2, SB);
    check("R11 still set", {7'd0, err}, 8'h01);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_restore();
    t_seek();
    t_sectors();
    t_abort();
    t_err();
    finish_run();
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end
endmodule